// File: doc/BRIEF.md
# PHY Control-Register Port Master

This block carries out single register reads and writes on a PHY's internal control-register port. It drives that port with a slow, software-style handshake and needs no processor to toggle each pin. A requester supplies a command (read or write), a 16-bit register address and, for writes, 16-bit data, then strobes start. The block produces the port's control clock, select line, address, write data and the separate read and write enables. It then watches the PHY's acknowledge.

Every transaction first clocks the port while select is low, to flush the PHY's interface logic. The block then raises select and presents the address and data. It fires the access by holding the matching enable across a single control-clock pulse. After that it polls the acknowledge, adding one control-clock pulse and a settle wait after every miss. When the acknowledge arrives the block reports done, with the captured read data for reads. If the polls run out it reports done with a one-cycle error and zero data. Any retry is left to the requester.

Top module: `phy_cr_master`

## Requirements
- R1: After reset, ready is 1 and done, error, cr_clk, cr_sel, cr_wr_en and cr_rd_en are all 0.
- R2: Each transaction begins with exactly 100 control-clock pulses while cr_sel is 0. Every pulse is high for HALF_PERIOD system clocks (default 4) and then low for at least HALF_PERIOD system clocks.
- R3: cr_sel rises after the idle pulses and stays 1 until the cycle in which done is raised, when it returns to 0.
- R4: At the start pulse, cr_addr holds the requested address. For a write, cr_wdata holds the write data. For a read, cr_wdata is 0.
- R5: Exactly one enable is high during the single start pulse: cr_wr_en for a write (req_write=1) and cr_rd_en for a read (req_write=0). The two are never high together and are never high while cr_sel is 0, and both fall together after that pulse.
- R6: After the start pulse, cr_ack is sampled. Each low sample adds one control-clock pulse and a settle wait before the next sample. A transaction acknowledged after k misses therefore emits 101+k pulses in total.
- R7: If cr_ack is low at 10 samples in a row, the transaction ends after 111 pulses with done and error both 1 and rdata equal to 0. A hit on the 10th sample still succeeds without error.
- R8: A successful read returns on rdata the value cr_rdata had when cr_ack was seen. A successful write returns rdata 0 with error 0.
- R9: ready is 0 from the cycle after an accepted start until done. A req_start during that time has no effect on the address used or on the number of transactions.
- R10: done and error are pulses one cycle long, and error is never 1 without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start a transaction (taken only when ready) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Idle and able to accept a start |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle acknowledge timeout flag, with done |
| rdata | output | 16 | Read result (0 on write or timeout) |
| cr_clk | output | 1 | Control-port clock |
| cr_sel | output | 1 | Control-port select |
| cr_addr | output | 16 | Control-port address |
| cr_wdata | output | 16 | Control-port write data |
| cr_wr_en | output | 1 | Control-port write enable |
| cr_rd_en | output | 1 | Control-port read enable |
| cr_ack | input | 1 | Control-port acknowledge |
| cr_rdata | input | 16 | Control-port read data |

## Verification
The transaction engine is exercised with reads and writes against a PHY model whose acknowledge arrives after 0, 3, 9 or never-counted poll pulses. The total pulse count separates an immediate hit from a hit after several misses, and a hit on the last permitted sample from a timeout. Read and write transactions with different addresses show that the right enable and the right data reach the port. A start pulsed in the middle of a transaction shows whether a busy engine really ignores it.

// File: rtl/phy_cr_pkg.sv
// Shared types for the control-register port master.
// Assumes: nothing beyond IEEE 1800-2017.
package phy_cr_pkg;

    // Transaction sequencer states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_SELECT,
        ST_PRESENT,
        ST_ENABLE,
        ST_STROBE,
        ST_SAMPLE,
        ST_POLLCLK,
        ST_SETTLE
    } seq_state_t;

endpackage

// File: rtl/cr_pulse_gen.sv
// Emits one full control-clock pulse per go request: HALF_PERIOD system
// clocks high, then HALF_PERIOD low, then a one-cycle pulse_done.
// Assumes: go is raised only while the generator is idle.
module cr_pulse_gen #(
    parameter int HALF_PERIOD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic cr_clk,
    output logic pulse_done
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    typedef enum logic [1:0] {PG_IDLE, PG_HIGH, PG_LOW} pg_state_t;

    pg_state_t     state;
    logic [CW-1:0] cnt;

    // Phase counter: high phase, then low phase, then report completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PG_IDLE;
            cnt        <= '0;
            cr_clk     <= 1'b0;
            pulse_done <= 1'b0;
        end else begin
            pulse_done <= 1'b0;
            case (state)
                PG_IDLE: begin
                    if (go) begin
                        state  <= PG_HIGH;
                        cnt    <= '0;
                        cr_clk <= 1'b1;
                    end
                end
                PG_HIGH: begin
                    if (cnt == CW'(HALF_PERIOD - 1)) begin
                        state  <= PG_LOW;
                        cnt    <= '0;
                        cr_clk <= 1'b0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PG_LOW: begin
                    if (cnt == CW'(HALF_PERIOD - 1)) begin
                        state      <= PG_IDLE;
                        pulse_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= PG_IDLE;
            endcase
        end
    end

    // R2: a go arriving mid-pulse would be lost
    go_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (state == PG_IDLE));

    // R2: the clock never stays high past its high phase
    clk_high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_clk |-> (state == PG_HIGH));

endmodule

// File: rtl/cr_sequencer.sv
// Runs one control-port transaction: flush pulses, select, address/data,
// enable strobe, then bounded acknowledge polling with settle waits.
// Assumes: pulse_done follows every pulse_go after a full control-clock pulse.
module cr_sequencer
    import phy_cr_pkg::*;
#(
    parameter int AW           = 16,
    parameter int DW           = 16,
    parameter int FLUSH_PULSES = 100,
    parameter int MAX_POLLS    = 10,
    parameter int SETTLE       = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          done,
    output logic          error,
    output logic [DW-1:0] rdata,
    output logic          pulse_go,
    input  logic          pulse_done,
    output logic          cr_sel,
    output logic [AW-1:0] cr_addr,
    output logic [DW-1:0] cr_wdata,
    output logic          cr_wr_en,
    output logic          cr_rd_en,
    input  logic          cr_ack,
    input  logic [DW-1:0] cr_rdata
);
    localparam int FW = $clog2(FLUSH_PULSES + 1);
    localparam int MW = $clog2(MAX_POLLS + 1);
    localparam int SW = $clog2(SETTLE + 1);

    seq_state_t    state;
    logic [FW-1:0] flush_cnt;
    logic [MW-1:0] miss_cnt;
    logic [SW-1:0] settle_cnt;
    logic          lat_write;
    logic [AW-1:0] lat_addr;
    logic [DW-1:0] lat_wdata;

    // Ready only while no transaction is in flight
    assign ready = (state == ST_IDLE);

    // Transaction state machine and port drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            flush_cnt  <= '0;
            miss_cnt   <= '0;
            settle_cnt <= '0;
            lat_write  <= 1'b0;
            lat_addr   <= '0;
            lat_wdata  <= '0;
            done       <= 1'b0;
            error      <= 1'b0;
            rdata      <= '0;
            pulse_go   <= 1'b0;
            cr_sel     <= 1'b0;
            cr_addr    <= '0;
            cr_wdata   <= '0;
            cr_wr_en   <= 1'b0;
            cr_rd_en   <= 1'b0;
        end else begin
            done     <= 1'b0;
            error    <= 1'b0;
            pulse_go <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_start) begin
                        lat_write <= req_write;
                        lat_addr  <= req_addr;
                        lat_wdata <= req_wdata;
                        flush_cnt <= '0;
                        pulse_go  <= 1'b1;
                        state     <= ST_FLUSH;
                    end
                end
                ST_FLUSH: begin
                    if (pulse_done) begin
                        if (flush_cnt == FW'(FLUSH_PULSES - 1)) begin
                            state <= ST_SELECT;
                        end else begin
                            flush_cnt <= flush_cnt + 1'b1;
                            pulse_go  <= 1'b1;
                        end
                    end
                end
                ST_SELECT: begin
                    cr_sel <= 1'b1;
                    state  <= ST_PRESENT;
                end
                ST_PRESENT: begin
                    cr_addr  <= lat_addr;
                    cr_wdata <= lat_write ? lat_wdata : '0;
                    state    <= ST_ENABLE;
                end
                ST_ENABLE: begin
                    cr_wr_en <= lat_write;
                    cr_rd_en <= !lat_write;
                    pulse_go <= 1'b1;
                    state    <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (pulse_done) begin
                        cr_wr_en <= 1'b0;
                        cr_rd_en <= 1'b0;
                        miss_cnt <= '0;
                        state    <= ST_SAMPLE;
                    end
                end
                ST_SAMPLE: begin
                    if (cr_ack) begin
                        done   <= 1'b1;
                        rdata  <= lat_write ? '0 : cr_rdata;
                        cr_sel <= 1'b0;
                        state  <= ST_IDLE;
                    end else begin
                        miss_cnt <= miss_cnt + 1'b1;
                        pulse_go <= 1'b1;
                        state    <= ST_POLLCLK;
                    end
                end
                ST_POLLCLK: begin
                    if (pulse_done) begin
                        settle_cnt <= '0;
                        state      <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SW'(SETTLE - 1)) begin
                        if (miss_cnt == MW'(MAX_POLLS)) begin
                            done   <= 1'b1;
                            error  <= 1'b1;
                            rdata  <= '0;
                            cr_sel <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_SAMPLE;
                        end
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    enables_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cr_wr_en, cr_rd_en}));

    // R5
    enable_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr_en || cr_rd_en) |-> cr_sel);

    // R3
    sel_drop_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cr_sel) |-> done);

    // R10
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    error_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // R7
    timeout_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (rdata == '0));

    // R7
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt <= MW'(MAX_POLLS));

endmodule

// File: rtl/phy_cr_master.sv
// Top of the control-register port master: a sequencer that steps each
// transaction and a pulse generator that forms the slow control clock.
// Assumes: cr_ack and cr_rdata are synchronous to clk.
module phy_cr_master #(
    parameter int HALF_PERIOD  = 4,
    parameter int FLUSH_PULSES = 100,
    parameter int MAX_POLLS    = 10,
    parameter int SETTLE       = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic        req_write,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        ready,
    output logic        done,
    output logic        error,
    output logic [15:0] rdata,
    output logic        cr_clk,
    output logic        cr_sel,
    output logic [15:0] cr_addr,
    output logic [15:0] cr_wdata,
    output logic        cr_wr_en,
    output logic        cr_rd_en,
    input  logic        cr_ack,
    input  logic [15:0] cr_rdata
);
    localparam int AW = 16;
    localparam int DW = 16;

    logic pulse_go;
    logic pulse_done;

    cr_sequencer #(
        .AW(AW), .DW(DW), .FLUSH_PULSES(FLUSH_PULSES),
        .MAX_POLLS(MAX_POLLS), .SETTLE(SETTLE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .error(error), .rdata(rdata),
        .pulse_go(pulse_go), .pulse_done(pulse_done),
        .cr_sel(cr_sel), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
        .cr_wr_en(cr_wr_en), .cr_rd_en(cr_rd_en),
        .cr_ack(cr_ack), .cr_rdata(cr_rdata)
    );

    cr_pulse_gen #(.HALF_PERIOD(HALF_PERIOD)) u_pulse (
        .clk(clk), .rst_n(rst_n), .go(pulse_go),
        .cr_clk(cr_clk), .pulse_done(pulse_done)
    );

endmodule

// File: tb/phy_cr_master_test.sv
// Directed bench: a PHY model answers after a chosen number of poll pulses.
module phy_cr_master_test;
    localparam int HALF = 4;
    localparam int TCLK = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ready, done, error;
    logic [15:0] rdata;
    logic        cr_clk, cr_sel, cr_wr_en, cr_rd_en;
    logic [15:0] cr_addr, cr_wdata;
    logic        cr_ack;
    logic [15:0] cr_rdata;

    int errors = 0;
    int checks = 0;

    // PHY model state
    int          ack_after = 0;
    bit          strobe_seen = 0;
    int          polls = 0;
    int          total_pulses = 0;
    int          flush_pulses = 0;
    int          strobe_cnt = 0;
    bit          cap_wr, cap_rd;
    logic [15:0] cap_addr, cap_wdata;
    int          width_bad = 0;
    int          low_bad = 0;
    int          sel_bad = 0;
    int          en_bad = 0;
    time         t_rise = 0;
    time         t_fall = 0;
    bit          prev_sel = 0;

    always #(TCLK/2) clk = ~clk;

    phy_cr_master uut (
        .clk(clk), .rst_n(rst_n),
        .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .done(done), .error(error), .rdata(rdata),
        .cr_clk(cr_clk), .cr_sel(cr_sel), .cr_addr(cr_addr), .cr_wdata(cr_wdata),
        .cr_wr_en(cr_wr_en), .cr_rd_en(cr_rd_en),
        .cr_ack(cr_ack), .cr_rdata(cr_rdata)
    );

    assign cr_ack   = strobe_seen && (polls >= ack_after);
    assign cr_rdata = cr_addr ^ 16'hC3A5;

    // Model: count pulses, capture the start pulse, count poll pulses
    always @(posedge cr_clk) begin
        total_pulses++;
        if (!cr_sel) flush_pulses++;
        if (t_fall != 0 && ($time - t_fall) < HALF*TCLK) low_bad++;
        t_rise = $time;
        if (cr_wr_en || cr_rd_en) begin
            strobe_cnt++;
            strobe_seen = 1;
            polls = 0;
            cap_wr = cr_wr_en;
            cap_rd = cr_rd_en;
            cap_addr = cr_addr;
            cap_wdata = cr_wdata;
        end else if (strobe_seen) begin
            polls++;
        end
    end

    always @(negedge cr_clk) begin
        if (($time - t_rise) != HALF*TCLK) width_bad++;
        t_fall = $time;
    end

    // Monitor select and enables between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_sel && !cr_sel && !done) sel_bad++;
            if (cr_wr_en && cr_rd_en) en_bad++;
            if ((cr_wr_en || cr_rd_en) && !cr_sel) en_bad++;
        end
        prev_sel = cr_sel;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear(input int after);
        ack_after = after;
        strobe_seen = 0;
        polls = 0;
        total_pulses = 0;
        flush_pulses = 0;
        strobe_cnt = 0;
        width_bad = 0;
        low_bad = 0;
        sel_bad = 0;
        en_bad = 0;
        t_fall = 0;
    endtask

    task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        req_write = wr;
        req_addr = a;
        req_wdata = d;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(ready == 1'b0, "R9 ready low while busy", ready, 0);
    endtask

    task automatic wait_done(output bit got_err, output logic [15:0] got_data, output bit ok);
        ok = 0;
        got_err = 0;
        got_data = '0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin
                ok = 1;
                got_err = error;
                got_data = rdata;
                break;
            end
            @(negedge clk);
        end
        chk(ok, "watchdog: transaction never completed", ok, 1);
        if (ok) begin
            @(negedge clk);
            chk(!done && !error, "R10 done/error one cycle", {done, error}, 0);
            chk(ready, "R9 ready after done", ready, 1);
        end
    endtask

    task automatic run_txn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                           input int after, input string name);
        bit          e, ok;
        logic [15:0] q;
        int          misses;
        bit          exp_err;
        logic [15:0] exp_q;
        misses  = (after > 10) ? 10 : after;
        exp_err = (after >= 10);
        exp_q   = (exp_err || wr) ? 16'h0000 : (a ^ 16'hC3A5);
        model_clear(after);
        issue(wr, a, d);
        wait_done(e, q, ok);
        $display("  %s: pulses=%0d err=%0d rdata=%0h", name, total_pulses, e, q);
        chk(flush_pulses == 100, "R2 flush pulse count", flush_pulses, 100);
        chk(width_bad == 0, "R2 high phase width", width_bad, 0);
        chk(low_bad == 0, "R2 low phase width", low_bad, 0);
        chk(sel_bad == 0, "R3 select held until done", sel_bad, 0);
        chk(!cr_sel, "R3 select low after done", cr_sel, 0);
        chk(cap_addr == a, "R4 address at start pulse", cap_addr, a);
        chk(cap_wdata == (wr ? d : 16'h0000), "R4 data at start pulse", cap_wdata, wr ? d : 0);
        chk(strobe_cnt == 1, "R5 single enable pulse", strobe_cnt, 1);
        chk(cap_wr == wr && cap_rd == !wr, "R5 enable matches command", {cap_wr, cap_rd}, {wr, !wr});
        chk(en_bad == 0, "R5 enables exclusive and under select", en_bad, 0);
        chk(!cr_wr_en && !cr_rd_en, "R5 enables dropped", {cr_wr_en, cr_rd_en}, 0);
        chk(total_pulses == 101 + misses, "R6 total pulses with polling", total_pulses, 101 + misses);
        chk(e == exp_err, "R7 timeout flag", e, exp_err);
        chk(q == exp_q, "R8 returned data", q, exp_q);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(ready && !done && !error, "R1 reset status", {ready, done, error}, 3'b100);
        chk(!cr_clk && !cr_sel && !cr_wr_en && !cr_rd_en, "R1 reset port lines",
            {cr_clk, cr_sel, cr_wr_en, cr_rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ignore_start();
        bit          e, ok;
        logic [15:0] q;
        int          dones;
        model_clear(0);
        issue(1'b0, 16'h0123, 16'h0000);
        repeat (60) @(negedge clk);
        req_addr = 16'h7777;
        req_write = 1'b1;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done(e, q, ok);
        chk(cap_addr == 16'h0123, "R9 mid-run start ignored (address)", cap_addr, 16'h0123);
        chk(q == (16'h0123 ^ 16'hC3A5), "R9 mid-run start ignored (data)", q, 16'h0123 ^ 16'hC3A5);
        dones = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        chk(dones == 0 && strobe_cnt == 1, "R9 no extra transaction", dones, 0);
    endtask

    initial begin
        #(200000 * TCLK);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        run_txn(1'b0, 16'h000F, 16'h0000, 0,  "read immediate ack");      // R8
        run_txn(1'b1, 16'h000F, 16'h1E40, 0,  "write immediate ack");     // R4
        run_txn(1'b0, 16'hA5F0, 16'h0000, 3,  "read after 3 misses");     // R6
        run_txn(1'b1, 16'hFFFF, 16'hBEEF, 9,  "write, ack on last poll"); // R7 boundary
        run_txn(1'b0, 16'h8001, 16'h0000, 50, "read timeout");            // R7
        t_ignore_start();                                                 // R9
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule